// File: doc/BRIEF.md
# Iterative SHA-256 Compression Core

This block applies the SHA-256 compression function to one 512-bit message block per operation. It computes one round per clock over a single round datapath and does not share adders. It keeps the 256-bit hash state from one operation to the next, so a multi-block message is hashed by one `init` command followed by `next` commands. Message padding and splitting the message into blocks are left to the surrounding logic.

An operation starts when the block is idle and `init_i` or `next_i` is high on a clock edge. `init_i` seeds the hash state with the standard SHA-256 initial values before compressing. `next_i` compresses on top of the digest left by the previous block. The block and the command are captured on that edge, so `block_i` is free to change while the core is working. The core spends one cycle loading the working variables, 64 cycles on the rounds and one cycle folding the result into the hash state. The new digest is therefore flagged valid 66 cycles after the command edge.

Top module: `sha256_iter`

## Requirements
- R1: While reset is asserted and on release, `ready_o` is 1, `digest_valid_o` is 0 and `digest_o` is all zeros.
- R2: An `init_i` command on the padded one-block message "abc" produces digest ba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad. Any block compressed after `init_i` equals SHA-256 compression of the standard initial values with that block. Word 0 of the block is `block_i[511:480]`, and `digest_o[255:224]` is hash word 0.
- R3: A `next_i` command compresses the block on top of the current `digest_o`. `init_i` on the first block of the standard 448-bit two-block test message, followed by `next_i` on the second block, gives 248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1.
- R4: A command is accepted only when `ready_o` is 1. `ready_o` and `digest_valid_o` are 0 after the command edge and through edge 65 after it. Both are 1 right after edge 66.
- R5: `block_i` is sampled only on the command edge. Changing it during an operation does not affect the digest.
- R6: `init_i` and `next_i` are ignored while `ready_o` is 0. They change neither the digest nor the latency.
- R7: When `init_i` and `next_i` are high together, the command acts as `init_i`.
- R8: Between operations, `digest_o` holds its value and `digest_valid_o` stays 1 until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Start a new message from the initial hash values |
| next_i | input | 1 | Compress a further block onto the current digest |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| ready_o | output | 1 | Idle and able to accept a command |
| digest_o | output | 256 | Hash state, word 0 in the top 32 bits |
| digest_valid_o | output | 1 | Digest reflects the last completed block |

## Verification
A wrong bit in the working variables, the schedule window or the round-constant index spreads through the later rounds. Any such error therefore shows up as a wrong `digest_o` at the first rise of `digest_valid_o`, 66 cycles after the command. A fault in the hash state or the chaining path shows only when a following `next_i` block completes. For that reason the sweep chains three blocks per message and compares every intermediate digest against an arithmetic model. A control fault shows up sooner: `ready_o` or `digest_valid_o` appears at a cycle other than edge 66, or a command issued while busy bends the result.

// File: rtl/sha_core_pkg.sv
package sha_core_pkg;
  localparam int WORD_W   = 32;
  localparam int N_SCHED  = 16;
  localparam int N_STATE  = 8;
  localparam int N_ROUNDS = 64;
  localparam int BLOCK_W  = WORD_W * N_SCHED;
  localparam int DIGEST_W = WORD_W * N_STATE;
  localparam int RND_W    = $clog2(N_ROUNDS);
  localparam int LATENCY  = N_ROUNDS + 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ROUND, ST_DONE} phase_t;

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_sig0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_sig1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(word_t e, word_t f, word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majority(word_t a, word_t b, word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic logic [0:N_STATE-1][WORD_W-1:0] seed_state();
    return {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
            32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  endfunction

  function automatic word_t round_const(logic [RND_W-1:0] idx);
    case (idx)
      6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491;
      6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
      6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1;
      6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
      6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01;
      6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
      6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe;
      6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
      6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786;
      6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
      6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa;
      6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
      6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d;
      6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
      6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147;
      6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
      6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138;
      6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
      6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb;
      6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
      6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b;
      6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
      6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624;
      6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
      6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08;
      6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
      6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a;
      6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
      6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f;
      6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
      6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb;
      6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
    endcase
  endfunction
endpackage

// File: rtl/sha_k_rom.sv
module sha_k_rom
  import sha_core_pkg::*;
(
  input  logic [RND_W-1:0] idx_i,
  output word_t            k_o
);
  // Combinational constant table, one word per round.
  assign k_o = round_const(idx_i);
endmodule

// File: rtl/sha_msg_sched.sv
module sha_msg_sched
  import sha_core_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [BLOCK_W-1:0] block_i,
  output word_t              w_o
);
  // Sixteen-word window; slot 0 always holds the word of the current round.
  logic [0:N_SCHED-1][WORD_W-1:0] win_q;
  word_t w_new;

  assign w_new = sml_sig1(win_q[N_SCHED-2]) + win_q[N_SCHED-7]
               + sml_sig0(win_q[1]) + win_q[0];
  assign w_o   = win_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (load_i) begin
      win_q <= block_i;
    end else if (shift_i) begin
      win_q <= {win_q[1:N_SCHED-1], w_new};
    end
  end

  // The window moves only on a capture or a round: block_i is otherwise unseen.
  p_window_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(win_q));
  p_window_slide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (win_q[0] == $past(win_q[1])));
endmodule

// File: rtl/sha_ctrl.sv
module sha_ctrl
  import sha_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             next_i,
  output logic             accept_o,
  output logic             seed_o,
  output logic             load_o,
  output logic             round_en_o,
  output logic             finish_o,
  output logic [RND_W-1:0] round_o,
  output logic             ready_o
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS - 1);

  phase_t           phase_q;
  logic [RND_W-1:0] round_q;

  assign ready_o    = (phase_q == ST_IDLE);
  assign accept_o   = ready_o && (init_i || next_i);
  assign seed_o     = init_i;          // init wins over next
  assign load_o     = (phase_q == ST_LOAD);
  assign round_en_o = (phase_q == ST_ROUND);
  assign finish_o   = (phase_q == ST_DONE);
  assign round_o    = round_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      round_q <= '0;
    end else begin
      case (phase_q)
        ST_IDLE:  if (accept_o) phase_q <= ST_LOAD;
        ST_LOAD: begin
          phase_q <= ST_ROUND;
          round_q <= '0;
        end
        ST_ROUND: begin
          round_q <= round_q + 1'b1;
          if (round_q == LAST_RND) phase_q <= ST_DONE;
        end
        default:  phase_q <= ST_IDLE;
      endcase
    end
  end

  p_busy_after_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !ready_o);
  p_load_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (round_en_o && round_o == '0));
  p_last_round_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (round_en_o && round_o == LAST_RND) |=> finish_o);
  p_one_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ready_o, load_o, round_en_o, finish_o}));
endmodule

// File: rtl/sha256_iter.sv
module sha256_iter
  import sha_core_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_i,
  input  logic                next_i,
  input  logic [BLOCK_W-1:0]  block_i,
  output logic                ready_o,
  output logic [DIGEST_W-1:0] digest_o,
  output logic                digest_valid_o
);
  logic             accept, seed, load, round_en, finish;
  logic [RND_W-1:0] round_idx;
  word_t            k_cur, w_cur, t1, t2;

  logic [0:N_STATE-1][WORD_W-1:0] hash_q;
  logic [0:N_STATE-1][WORD_W-1:0] var_q;
  logic                           valid_q;

  sha_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .next_i     (next_i),
    .accept_o   (accept),
    .seed_o     (seed),
    .load_o     (load),
    .round_en_o (round_en),
    .finish_o   (finish),
    .round_o    (round_idx),
    .ready_o    (ready_o)
  );

  sha_k_rom u_rom (
    .idx_i (round_idx),
    .k_o   (k_cur)
  );

  sha_msg_sched u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .shift_i (round_en),
    .block_i (block_i),
    .w_o     (w_cur)
  );

  // One compression round on the working variables a..h = var_q[0..7].
  always_comb begin
    t1 = var_q[7] + big_sig1(var_q[4]) + choose(var_q[4], var_q[5], var_q[6])
       + k_cur + w_cur;
    t2 = big_sig0(var_q[0]) + majority(var_q[0], var_q[1], var_q[2]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hash_q  <= '0;
      var_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (accept) begin
        valid_q <= 1'b0;
        if (seed) hash_q <= seed_state();
      end
      if (load) begin
        var_q <= hash_q;
      end else if (round_en) begin
        var_q <= {t1 + t2, var_q[0], var_q[1], var_q[2],
                  var_q[3] + t1, var_q[4], var_q[5], var_q[6]};
      end
      if (finish) begin
        for (int i = 0; i < N_STATE; i++) hash_q[i] <= hash_q[i] + var_q[i];
        valid_q <= 1'b1;
      end
    end
  end

  assign digest_o       = hash_q;
  assign digest_valid_o = valid_q;

  // Cycles since the last accepted command, for the latency check.
  logic [RND_W:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       lat_q <= '0;
    else if (accept)  lat_q <= '0;
    else if (!ready_o) lat_q <= lat_q + 1'b1;
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digest_valid_o) |-> (lat_q == (RND_W+1)'(LATENCY)));
  p_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    digest_valid_o |-> ready_o);
  p_digest_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !init_i && !next_i) |=> $stable(digest_o));
  p_busy_cmd_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !finish && (init_i || next_i)) |=> $stable(digest_o));
  p_seed_on_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && init_i) |=> (digest_o[DIGEST_W-1 -: WORD_W] == 32'h6a09e667));
endmodule

// File: tb/sha256_iter_bench.sv
module sha256_iter_bench;
  logic         clk = 1'b0;
  logic         rst_n, init_i, next_i;
  logic [511:0] block_i;
  logic         ready_o, digest_valid_o;
  logic [255:0] digest_o;

  always #5 clk = ~clk;

  sha256_iter u_sha256_iter (
    .clk            (clk),
    .rst_n          (rst_n),
    .init_i         (init_i),
    .next_i         (next_i),
    .block_i        (block_i),
    .ready_o        (ready_o),
    .digest_o       (digest_o),
    .digest_valid_o (digest_valid_o)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 0;
  int unsigned kt[64];
  logic [255:0] iv_ref;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned rr(int unsigned x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // Independent compression model: full 64-word schedule, named temporaries.
  function automatic logic [255:0] compress(logic [255:0] hin, logic [511:0] blk);
    int unsigned w[64];
    int unsigned s[8];
    int unsigned x1, x2, s0, s1;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = blk[511 - 32*t -: 32];
    for (int t = 16; t < 64; t++) begin
      s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
      s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
      w[t] = w[t-16] + s0 + w[t-7] + s1;
    end
    for (int i = 0; i < 8; i++) s[i] = hin[255 - 32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      x1 = s[7] + (rr(s[4], 6) ^ rr(s[4], 11) ^ rr(s[4], 25))
         + ((s[4] & s[5]) | (~s[4] & s[6])) + kt[t] + w[t];
      x2 = (rr(s[0], 2) ^ rr(s[0], 13) ^ rr(s[0], 22))
         + ((s[0] & s[1]) | (s[2] & (s[0] | s[1])));
      for (int i = 7; i > 0; i--) s[i] = s[i-1];
      s[4] = s[4] + x1;
      s[0] = x1 + x2;
    end
    for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = 32'(hin[255 - 32*i -: 32] + s[i]);
    return r;
  endfunction

  // Constants from fractional parts of prime roots.
  task automatic build_tables();
    int cnt = 0;
    int p = 2;
    real f;
    while (cnt < 64) begin
      bit prime = 1;
      for (int d = 2; d * d <= p; d++) if (p % d == 0) prime = 0;
      if (prime) begin
        f = $pow(real'(p), 1.0 / 3.0);
        kt[cnt] = 32'(longint'($floor((f - $floor(f)) * 4294967296.0)));
        if (cnt < 8) begin
          f = $sqrt(real'(p));
          iv_ref[255 - 32*cnt -: 32] = 32'(longint'($floor((f - $floor(f)) * 4294967296.0)));
        end
        cnt++;
      end
      p++;
    end
  endtask

  function automatic logic [511:0] rand_block();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  // Issue a command, optionally scrambling block_i and poking commands while busy.
  task automatic run_op(input bit di, input bit dn, input logic [511:0] blk,
                        input bit scramble, input bit poke, output logic [255:0] dig);
    bit lat_ok = 1;
    @(negedge clk);
    init_i = di; next_i = dn; block_i = blk;
    @(negedge clk);
    init_i = 0; next_i = 0;
    for (int k = 1; k <= 65; k++) begin
      if (ready_o !== 1'b0 || digest_valid_o !== 1'b0) lat_ok = 0;
      if (scramble) block_i = rand_block();
      if (poke) begin
        init_i = (k % 5 == 1);
        next_i = (k % 7 == 3);
      end
      @(negedge clk);
    end
    if (ready_o !== 1'b0 || digest_valid_o !== 1'b0) lat_ok = 0;
    init_i = 0; next_i = 0;
    @(negedge clk);
    if (ready_o !== 1'b1 || digest_valid_o !== 1'b1) lat_ok = 0;
    chk("R4 latency/ready", {255'd0, lat_ok}, 256'd1);
    dig = digest_o;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [511:0] abc, b1, b2, blk;
    logic [255:0] d, chain, held;
    build_tables();
    rst_n = 0; init_i = 0; next_i = 0; block_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready",  {255'd0, ready_o}, 256'd1);
    chk("R1 valid",  {255'd0, digest_valid_o}, 256'd0);
    chk("R1 digest", digest_o, 256'd0);
    rst_n = 1;

    abc = '0; abc[511:480] = 32'h61626380; abc[31:0] = 32'd24;
    run_op(1, 0, abc, 0, 0, d);
    chk("R2 abc known", d,
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
    chk("R2 abc model", d, compress(iv_ref, abc));

    b1 = '0; b2 = '0;
    for (int i = 0; i < 14; i++)
      b1[511 - 32*i -: 32] = {8'(97+i), 8'(98+i), 8'(99+i), 8'(100+i)};
    b1[63:32] = 32'h80000000;
    b2[31:0]  = 32'd448;
    run_op(1, 0, b1, 0, 0, d);
    chk("R2 block1 model", d, compress(iv_ref, b1));
    run_op(0, 1, b2, 0, 0, d);
    chk("R3 two-block known", d,
        256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1);

    held = digest_o;
    repeat (8) @(negedge clk);
    chk("R8 digest held", digest_o, held);
    chk("R8 valid held", {255'd0, digest_valid_o}, 256'd1);

    // Sweep: three-block chains, all scramble/poke combinations.
    for (int trial = 0; trial < 12; trial++) begin
      bit sc = trial[0];
      bit pk = trial[1];
      chain = iv_ref;
      for (int j = 0; j < 3; j++) begin
        blk = rand_block();
        run_op(j == 0, j != 0, blk, sc, pk, d);
        chain = compress(chain, blk);
        if (pk)      chk("R6 busy commands ignored", d, chain);
        else if (sc) chk("R5 block sampled once", d, chain);
        else         chk("R3 chained next", d, chain);
      end
    end

    blk = rand_block();
    run_op(1, 1, blk, 0, 0, d);
    chk("R7 init priority", d, compress(iv_ref, blk));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule